// File: doc/BRIEF.md
# Planar Display Controller Register File

This block holds the two indexed register banks of a classic planar display adapter: a sequencer bank and a graphics-controller bank. Each bank has a byte-wide index port and a byte-wide data port. A write to an index port selects a register. A write to the data port then stores the byte into the selected register, after the bits that the register does not implement are cleared. Reads return the current index, or the content of the selected register. The lower registers of both banks are brought out as flat vectors, so that the video-memory datapath can use the current plane, mode and mask settings without a port access.

The host sends requests of 1, 2, 4 or 8 bytes. The block splits each request into byte operations at ascending port addresses, one per clock, with the least significant byte first. A 16-bit write to an index port therefore sets the index with its low byte and writes the selected register with its high byte. For each read, the block reports whether every byte could be answered from local state. The block also watches two registers for the standard planar memory configuration. When that configuration starts, it sets a sticky cache-enable flag and raises a one-cycle restart pulse.

Top module: `planar_ctl_regs`

## Requirements
- R1: The sequencer index port is at 0x3C4 and the graphics index port is at 0x3CE. A read of either index port returns the last byte written to that port.
- R2: A sequencer data write (port 0x3C5) to index 0..5 or 7 stores the byte ANDed with a fixed keep mask. The masks are: index 0 → 0x03, 1 → 0x3D, 2 → 0x0F, 3 → 0x3F, 4 → 0x0E, 5 → 0x00, 7 → 0xFF. Byte k of `seq_regs` (bits 8k+7..8k) shows sequencer register k.
- R3: A sequencer data write to index 6 stores 0x12 when (byte & 0x17) == 0x12, and stores 0x0F for any other byte.
- R4: A graphics data write (port 0x3CF) to index 0..8 stores the byte ANDed with the keep mask for that index: 0 → 0x0F, 1 → 0x0F, 2 → 0x0F, 3 → 0x1F, 4 → 0x03, 5 → 0x7B, 6 → 0x0F, 7 → 0x0F, 8 → 0xFF. Indices 9..255 store the byte unchanged. Byte k of `gfx_regs` shows graphics register k for k = 0..8.
- R5: A sequencer data write with index 8 or above changes no register. A sequencer data read with index 8 or above returns 0x00.
- R6: `std_mode` is high exactly when sequencer register 7 equals 0x00 and graphics register 6 equals 0x05. It follows a byte write that changes either register at the second rising edge after the write's strobe edge.
- R7: When `std_mode` goes from low to high, `cache_restart` is high for exactly one cycle, in the same cycle as the rise, and `cache_en` becomes 1. `cache_en` stays 1 after `std_mode` falls. Only reset clears it.
- R8: `rsp_local` is 0 when any byte of the read accessed the sequencer data port with index 8 or above, or the graphics data port with index 9 or above. Otherwise it is 1.
- R9: `req_size` selects 1, 2, 4 or 8 bytes (codes 0, 1, 2, 3). Byte k of `req_wdata` or `rsp_rdata` (bits 8k+7..8k) goes to or comes from port address `req_addr`+k, and the bytes are handled in ascending order. After a request of N bytes is accepted, `req_ready` stays low for N-1 cycles.
- R10: A read response appears N cycles after the accepting edge, for N bytes. A 1-byte read is therefore answered one cycle after its strobe. `rsp_valid` is high for exactly one cycle.
- R11: A synchronous, active-high reset clears both indices, the exposed registers, the flags and `rsp_valid`, and leaves `req_ready` high. The graphics registers at index 9 and above are stored in a RAM, and reset does not clear them.
- R12: A byte at any port address other than the four listed ports is ignored on a write and reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; the request is taken when `req_ready` is also high |
| req_ready | output | 1 | High when a new request can be taken |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 16 | Port address of the lowest byte |
| req_size | input | 2 | Access size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes) |
| req_wdata | input | 64 | Write data, byte k for address + k |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 64 | Read data, byte k from address + k; unused bytes are zero |
| rsp_local | output | 1 | Every byte of the read was answered from local state |
| std_mode | output | 1 | Standard planar configuration flag |
| cache_en | output | 1 | Sticky flag, set when the standard configuration is entered |
| cache_restart | output | 1 | One-cycle pulse when the standard configuration is entered |
| seq_regs | output | 64 | Sequencer registers 0..7, one byte each |
| gfx_regs | output | 72 | Graphics registers 0..8, one byte each |

## Verification
Each result has its own due cycle. For an N-byte read accepted at edge E, the response is due in the cycle after edge E+N-1. An exposed register changes at the edge that takes its byte. `std_mode` and `cache_restart` respond one edge later still. The driver records the due cycle with each expected read response in a queue. The monitor samples on the falling clock edge and fails any response that arrives in another cycle. The mode and exposed-register checks are made at falling edges that the driver counts from the accepting edge, and the driver also counts the cycles `req_ready` stays low after each request.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

  typedef enum logic [2:0] {
    PT_NONE    = 3'd0,
    PT_SEQ_IDX = 3'd1,
    PT_SEQ_DAT = 3'd2,
    PT_GFX_IDX = 3'd3,
    PT_GFX_DAT = 3'd4
  } port_e;

  typedef struct packed {
    logic       wr;
    logic       rd;
    port_e      port;
    logic [7:0] wdata;
  } byte_op_t;

  // Implemented bits of the sequencer registers
  function automatic logic [7:0] seq_keep(input logic [7:0] idx);
    case (idx)
      8'd0:    return 8'h03;
      8'd1:    return 8'h3D;
      8'd2:    return 8'h0F;
      8'd3:    return 8'h3F;
      8'd4:    return 8'h0E;
      8'd5:    return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // Implemented bits of the masked graphics registers
  function automatic logic [7:0] gfx_keep(input logic [7:0] idx);
    case (idx)
      8'd3:    return 8'h1F;
      8'd4:    return 8'h03;
      8'd5:    return 8'h7B;
      8'd8:    return 8'hFF;
      default: return 8'h0F;
    endcase
  endfunction

  // Sequencer register 6 accepts only two codes
  function automatic logic [7:0] seq_unlock_code(input logic [7:0] v);
    return ((v & 8'h17) == 8'h12) ? 8'h12 : 8'h0F;
  endfunction

endpackage

// File: rtl/pcr_byte_split.sv
module pcr_byte_split
  import pcr_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              MAX_BYTES = 8,
  parameter logic [ADDR_W-1:0] SEQ_BASE  = 16'h03C4,
  parameter logic [ADDR_W-1:0] GFX_BASE  = 16'h03CE,
  localparam int             LANE_W    = $clog2(MAX_BYTES),
  localparam int             SZ_W      = $clog2(LANE_W + 1),
  localparam int             DATA_W    = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output byte_op_t          op,
  input  logic              byte_local,
  input  logic [7:0]        rd_byte,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_local
);

  localparam int CNT_W = LANE_W + 1;

  function automatic port_e decode(input logic [ADDR_W-1:0] a);
    if (a == SEQ_BASE)                  return PT_SEQ_IDX;
    if (a == SEQ_BASE + ADDR_W'(1))     return PT_SEQ_DAT;
    if (a == GFX_BASE)                  return PT_GFX_IDX;
    if (a == GFX_BASE + ADDR_W'(1))     return PT_GFX_DAT;
    return PT_NONE;
  endfunction

  logic              busy_q;
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_q;
  logic [LANE_W-1:0] lane_q;

  logic              accept;
  logic [CNT_W-1:0]  nbytes;
  logic              issue;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        cur_byte;
  logic              cur_wr;
  logic [LANE_W-1:0] cur_lane;
  logic              cur_last;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign nbytes    = CNT_W'(1) << req_size;

  // Byte 0 leaves in the accepting cycle, later bytes from the held request
  always_comb begin
    issue    = 1'b0;
    cur_addr = addr_q;
    cur_byte = data_q[7:0];
    cur_wr   = wr_q;
    cur_lane = lane_q;
    cur_last = (left_q == CNT_W'(1));
    if (accept) begin
      issue    = 1'b1;
      cur_addr = req_addr;
      cur_byte = req_wdata[7:0];
      cur_wr   = req_write;
      cur_lane = '0;
      cur_last = (req_size == '0);
    end else if (busy_q) begin
      issue = 1'b1;
    end
  end

  always_comb begin
    op.wr    = issue && cur_wr;
    op.rd    = issue && !cur_wr;
    op.port  = decode(cur_addr);
    op.wdata = cur_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      left_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      wr_q   <= 1'b0;
      lane_q <= '0;
    end else if (accept) begin
      busy_q <= (req_size != '0);
      left_q <= nbytes - CNT_W'(1);
      addr_q <= req_addr + ADDR_W'(1);
      data_q <= req_wdata >> 8;
      wr_q   <= req_write;
      lane_q <= LANE_W'(1);
    end else if (busy_q) begin
      busy_q <= (left_q != CNT_W'(1));
      left_q <= left_q - CNT_W'(1);
      addr_q <= addr_q + ADDR_W'(1);
      data_q <= data_q >> 8;
      lane_q <= lane_q + LANE_W'(1);
    end
  end

  // Read collection: bank bytes arrive one cycle after their issue
  logic              rd_pend_q;
  logic [LANE_W-1:0] rd_lane_q;
  logic              rd_last_q;
  logic              local_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] placed;

  assign placed = DATA_W'(rd_byte) << {rd_lane_q, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q <= 1'b0;
      rd_lane_q <= '0;
      rd_last_q <= 1'b0;
      local_q   <= 1'b0;
      acc_q     <= '0;
    end else begin
      rd_pend_q <= issue && !cur_wr;
      rd_lane_q <= cur_lane;
      rd_last_q <= cur_last;
      if (issue && !cur_wr)
        local_q <= ((cur_lane == '0) ? 1'b1 : local_q) & byte_local;
      if (issue && !cur_wr && cur_lane == '0)
        acc_q <= '0;
      else if (rd_pend_q)
        acc_q <= acc_q | placed;
    end
  end

  assign rsp_valid = rd_pend_q && rd_last_q;
  assign rsp_rdata = acc_q | placed;
  assign rsp_local = local_q;

  // R9: a wide request holds off the next one
  p_busy_after_wide_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && req_size != '0) |=> !req_ready);

  // R10: every response follows a read byte issued one cycle earlier
  p_rsp_follows_read_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(op.rd));

endmodule

// File: rtl/pcr_seq_bank.sv
module pcr_seq_bank
  import pcr_pkg::*;
#(
  parameter int  SEQ_REGS = 8,
  localparam int SEL_W    = $clog2(SEQ_REGS),
  localparam int FLAT_W   = SEQ_REGS * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  byte_op_t          op,
  output logic [7:0]        idx,
  output logic [FLAT_W-1:0] regs_flat,
  output logic [7:0]        rd_byte
);

  localparam logic [7:0] REGS_B   = 8'(SEQ_REGS);
  localparam logic [7:0] CODE_IDX = 8'd6;

  logic [7:0] idx_q;
  logic [7:0] regs_q [SEQ_REGS];
  logic [7:0] rd_q;
  logic       in_range;
  logic [7:0] wr_val;
  logic [7:0] rd_val;

  assign in_range = (idx_q < REGS_B);
  assign wr_val   = (idx_q == CODE_IDX) ? seq_unlock_code(op.wdata)
                                        : (op.wdata & seq_keep(idx_q));

  always_comb begin
    rd_val = 8'h00;
    if (op.port == PT_SEQ_IDX)
      rd_val = idx_q;
    else if (op.port == PT_SEQ_DAT && in_range)
      rd_val = regs_q[idx_q[SEL_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= 8'h00;
      rd_q  <= 8'h00;
      for (int i = 0; i < SEQ_REGS; i++) regs_q[i] <= 8'h00;
    end else begin
      if (op.wr && op.port == PT_SEQ_IDX)
        idx_q <= op.wdata;
      if (op.wr && op.port == PT_SEQ_DAT && in_range)
        regs_q[idx_q[SEL_W-1:0]] <= wr_val;
      if (op.rd)
        rd_q <= rd_val;
    end
  end

  for (genvar k = 0; k < SEQ_REGS; k++) begin : g_flat
    assign regs_flat[k*8 +: 8] = regs_q[k];
  end

  assign idx     = idx_q;
  assign rd_byte = rd_q;

  // R5: an out-of-range data read answers zero
  p_oob_read_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (op.rd && op.port == PT_SEQ_DAT && !in_range) |=> rd_q == 8'h00);

  if (SEQ_REGS > 6) begin : g_code_chk
    // R3: register 6 only ever holds one of its two codes or its reset value
    p_code_reg_r3: assert property (@(posedge clk) disable iff (rst)
      (op.wr && op.port == PT_SEQ_DAT && idx_q == CODE_IDX)
        |=> (regs_q[6] == 8'h12 || regs_q[6] == 8'h0F));
  end

endmodule

// File: rtl/pcr_gfx_bank.sv
module pcr_gfx_bank
  import pcr_pkg::*;
#(
  parameter int  IDX_W    = 8,
  parameter int  GFX_LO   = 9,
  localparam int GFX_REGS = 1 << IDX_W,
  localparam int LO_SEL_W = $clog2(GFX_LO),
  localparam int FLAT_W   = GFX_LO * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  byte_op_t          op,
  output logic [7:0]        idx,
  output logic [FLAT_W-1:0] regs_flat,
  output logic [7:0]        rd_byte
);

  localparam logic [7:0] LO_B = 8'(GFX_LO);

  logic [7:0] idx_q;
  logic [7:0] lo_q [GFX_LO];
  logic [7:0] mem [GFX_REGS];
  logic [7:0] mem_q;
  logic [7:0] rd_q;
  logic       from_mem_q;
  logic       lo_sel;
  logic       dat_wr;
  logic [7:0] rd_val;

  assign lo_sel = (idx_q < LO_B);
  assign dat_wr = op.wr && op.port == PT_GFX_DAT;

  always_comb begin
    rd_val = 8'h00;
    if (op.port == PT_GFX_IDX)
      rd_val = idx_q;
    else if (op.port == PT_GFX_DAT && lo_sel)
      rd_val = lo_q[idx_q[LO_SEL_W-1:0]];
  end

  // Masked registers in flops, visible to the memory datapath
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= 8'h00;
      rd_q       <= 8'h00;
      from_mem_q <= 1'b0;
      for (int i = 0; i < GFX_LO; i++) lo_q[i] <= 8'h00;
    end else begin
      if (op.wr && op.port == PT_GFX_IDX)
        idx_q <= op.wdata;
      if (dat_wr && lo_sel)
        lo_q[idx_q[LO_SEL_W-1:0]] <= op.wdata & gfx_keep(idx_q);
      if (op.rd) begin
        rd_q       <= rd_val;
        from_mem_q <= (op.port == PT_GFX_DAT) && !lo_sel;
      end
    end
  end

  // Upper registers in a single-port RAM with registered read
  always_ff @(posedge clk) begin
    if (dat_wr && !lo_sel)
      mem[idx_q[IDX_W-1:0]] <= op.wdata;
    if (op.rd)
      mem_q <= mem[idx_q[IDX_W-1:0]];
  end

  for (genvar k = 0; k < GFX_LO; k++) begin : g_flat
    assign regs_flat[k*8 +: 8] = lo_q[k];
  end

  assign idx     = idx_q;
  assign rd_byte = from_mem_q ? mem_q : rd_q;

  // R1: the index port keeps the last byte written to it
  p_index_track_r1: assert property (@(posedge clk) disable iff (rst)
    (op.wr && op.port == PT_GFX_IDX) |=> idx_q == $past(op.wdata));

endmodule

// File: rtl/pcr_mode_track.sv
module pcr_mode_track #(
  parameter logic [7:0] STD_SEQ_VAL = 8'h00,
  parameter logic [7:0] STD_GFX_VAL = 8'h05
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] seq_sel,
  input  logic [7:0] gfx_sel,
  output logic       std_mode,
  output logic       cache_en,
  output logic       cache_restart
);

  logic std_now;
  logic mode_q;
  logic cache_q;
  logic restart_q;

  assign std_now = (seq_sel == STD_SEQ_VAL) && (gfx_sel == STD_GFX_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 1'b0;
      cache_q   <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      mode_q    <= std_now;
      restart_q <= std_now && !mode_q;
      if (std_now && !mode_q)
        cache_q <= 1'b1;
    end
  end

  assign std_mode      = mode_q;
  assign cache_en      = cache_q;
  assign cache_restart = restart_q;

  // R7: the restart pulse coincides with the rise of the mode flag
  p_restart_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
    cache_restart |-> (std_mode && !$past(std_mode)));

  // R7: the cache-enable flag is sticky
  p_cache_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    $past(cache_en) |-> cache_en);

endmodule

// File: rtl/planar_ctl_regs.sv
module planar_ctl_regs
  import pcr_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              MAX_BYTES = 8,
  parameter int              SEQ_REGS  = 8,
  parameter int              IDX_W     = 8,
  parameter int              GFX_LO    = 9,
  parameter logic [ADDR_W-1:0] SEQ_BASE  = 16'h03C4,
  parameter logic [ADDR_W-1:0] GFX_BASE  = 16'h03CE,
  localparam int             LANE_W    = $clog2(MAX_BYTES),
  localparam int             SZ_W      = $clog2(LANE_W + 1),
  localparam int             DATA_W    = MAX_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [SZ_W-1:0]       req_size,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  rsp_local,
  output logic                  std_mode,
  output logic                  cache_en,
  output logic                  cache_restart,
  output logic [SEQ_REGS*8-1:0] seq_regs,
  output logic [GFX_LO*8-1:0]   gfx_regs
);

  localparam logic [7:0] SEQ_LIM = 8'(SEQ_REGS);
  localparam logic [7:0] GFX_LIM = 8'(GFX_LO);

  byte_op_t   op;
  logic [7:0] seq_idx;
  logic [7:0] gfx_idx;
  logic [7:0] seq_rd;
  logic [7:0] gfx_rd;
  logic       byte_local;

  // A data read past the masked range cannot be answered locally
  assign byte_local = !((op.port == PT_SEQ_DAT) && (seq_idx >= SEQ_LIM)) &&
                      !((op.port == PT_GFX_DAT) && (gfx_idx >= GFX_LIM));

  pcr_byte_split #(
    .ADDR_W   (ADDR_W),
    .MAX_BYTES(MAX_BYTES),
    .SEQ_BASE (SEQ_BASE),
    .GFX_BASE (GFX_BASE)
  ) u_split (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .op        (op),
    .byte_local(byte_local),
    .rd_byte   (seq_rd | gfx_rd),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_local (rsp_local)
  );

  pcr_seq_bank #(
    .SEQ_REGS(SEQ_REGS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .idx      (seq_idx),
    .regs_flat(seq_regs),
    .rd_byte  (seq_rd)
  );

  pcr_gfx_bank #(
    .IDX_W (IDX_W),
    .GFX_LO(GFX_LO)
  ) u_gfx (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .idx      (gfx_idx),
    .regs_flat(gfx_regs),
    .rd_byte  (gfx_rd)
  );

  pcr_mode_track u_mode (
    .clk          (clk),
    .rst          (rst),
    .seq_sel      (seq_regs[7*8 +: 8]),
    .gfx_sel      (gfx_regs[6*8 +: 8]),
    .std_mode     (std_mode),
    .cache_en     (cache_en),
    .cache_restart(cache_restart)
  );

endmodule

// File: tb/planar_ctl_regs_tb.sv
module planar_ctl_regs_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [1:0]  req_size = 2'd0;
  logic [63:0] req_wdata = 64'h0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        rsp_local;
  logic        std_mode, cache_en, cache_restart;
  logic [63:0] seq_regs;
  logic [71:0] gfx_regs;

  always #5 clk = ~clk;

  planar_ctl_regs u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_local(rsp_local), .std_mode(std_mode), .cache_en(cache_en),
    .cache_restart(cache_restart), .seq_regs(seq_regs), .gfx_regs(gfx_regs)
  );

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  // Reference model
  logic [7:0] m_seq [8];
  logic [7:0] m_gfx [256];
  logic [7:0] m_sidx, m_gidx;

  // Scoreboard queues
  logic [63:0] q_d[$];
  bit          q_l[$];
  int          q_due[$];
  string       q_tag[$];

  function automatic logic [7:0] ref_seq(input int i, input logic [7:0] v);
    case (i)
      0: return v & 8'h03;
      1: return v & 8'h3D;
      2: return v & 8'h0F;
      3: return v & 8'h3F;
      4: return v & 8'h0E;
      5: return 8'h00;
      6: return ((v & 8'h17) == 8'h12) ? 8'h12 : 8'h0F;
      default: return v;
    endcase
  endfunction

  function automatic logic [7:0] ref_gfx(input int i, input logic [7:0] v);
    case (i)
      0, 1, 2, 6, 7: return v & 8'h0F;
      3: return v & 8'h1F;
      4: return v & 8'h03;
      5: return v & 8'h7B;
      default: return v;
    endcase
  endfunction

  task automatic model_wr(input logic [15:0] a, input logic [7:0] v);
    case (a)
      16'h03C4: m_sidx = v;
      16'h03C5: if (m_sidx < 8) m_seq[m_sidx] = ref_seq(int'(m_sidx), v);
      16'h03CE: m_gidx = v;
      16'h03CF: m_gfx[m_gidx] = ref_gfx(int'(m_gidx), v);
      default: ;
    endcase
  endtask

  task automatic model_rd(input logic [15:0] a, output logic [7:0] v, inout bit loc);
    v = 8'h00;
    case (a)
      16'h03C4: v = m_sidx;
      16'h03C5: begin
        if (m_sidx < 8) v = m_seq[m_sidx];
        else loc = 1'b0;
      end
      16'h03CE: v = m_gidx;
      16'h03CF: begin
        v = m_gfx[m_gidx];
        if (m_gidx >= 9) loc = 1'b0;
      end
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    logic [63:0] es;
    logic [71:0] eg;
    for (int k = 0; k < 8; k++) es[k*8 +: 8] = m_seq[k];
    for (int k = 0; k < 9; k++) eg[k*8 +: 8] = m_gfx[k];
    check({tag, " seq_regs"}, {8'h00, seq_regs}, {8'h00, es});
    check({tag, " gfx_regs"}, gfx_regs, eg);
  endtask

  // Driver: called and returns at a falling edge
  task automatic send(input string tag, input bit wr, input logic [15:0] a,
                      input logic [1:0] sz, input logic [63:0] d);
    int n = 1 << sz;
    int waits = 0;
    logic [63:0] ed = 64'h0;
    bit loc = 1'b1;
    while (!req_ready) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (wr) model_wr(a + 16'(k), d[k*8 +: 8]);
      else begin
        logic [7:0] b;
        model_rd(a + 16'(k), b, loc);
        ed[k*8 +: 8] = b;
      end
    end
    if (!wr) begin
      q_d.push_back(ed); q_l.push_back(loc);
      q_due.push_back(cyc + n); q_tag.push_back(tag);
    end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) begin
      waits++;
      @(negedge clk);
    end
    if (n > 1) check({tag, " R9 ready-low cycles"}, 72'(waits), 72'(n - 1));
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_d.size() == 0) begin
        n_checks++; n_errors++;
        $display("FAIL R10 unexpected response: actual=%h expected=none", rsp_rdata);
      end else begin
        logic [63:0] ed;
        bit el;
        int due;
        string tg;
        ed = q_d.pop_front(); el = q_l.pop_front();
        due = q_due.pop_front(); tg = q_tag.pop_front();
        check({tg, " data"}, {8'h00, rsp_rdata}, {8'h00, ed});
        check({tg, " R8 local"}, 72'(rsp_local), 72'(el));
        check({tg, " R10 cycle"}, 72'(cyc), 72'(due));
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) m_seq[k] = 8'h00;
    for (int k = 0; k < 256; k++) m_gfx[k] = 8'h00;
    m_sidx = 8'h00; m_gidx = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check_regs("R11");
    check("R11 flags", 72'({std_mode, cache_en, cache_restart, rsp_valid}), 72'(0));
    check("R11 ready", 72'(req_ready), 72'(1));
    send("R11 seq index", 1'b0, 16'h03C4, 2'd0, 64'h0);

    // R1 index readback
    send("R1", 1'b1, 16'h03C4, 2'd0, 64'h03);
    send("R1 seq index", 1'b0, 16'h03C4, 2'd0, 64'h0);
    send("R1", 1'b1, 16'h03CE, 2'd0, 64'hC5);
    send("R1 gfx index", 1'b0, 16'h03CE, 2'd0, 64'h0);

    // R2 sequencer masks
    for (int i = 0; i < 8; i++) begin
      if (i != 6) begin
        send("R2", 1'b1, 16'h03C4, 2'd0, 64'(i));
        send("R2", 1'b1, 16'h03C5, 2'd0, 64'hFF);
        send("R2 seq data", 1'b0, 16'h03C5, 2'd0, 64'h0);
      end
    end
    check_regs("R2");

    // R3 sequencer index 6 codes
    send("R3", 1'b1, 16'h03C4, 2'd0, 64'h06);
    send("R3", 1'b1, 16'h03C5, 2'd0, 64'h12);
    send("R3 exact code", 1'b0, 16'h03C5, 2'd0, 64'h0);
    send("R3", 1'b1, 16'h03C5, 2'd0, 64'hFA);
    send("R3 code with free bits", 1'b0, 16'h03C5, 2'd0, 64'h0);
    send("R3", 1'b1, 16'h03C5, 2'd0, 64'h13);
    send("R3 other value", 1'b0, 16'h03C5, 2'd0, 64'h0);
    check_regs("R3");

    // R4 graphics masks and unmasked upper registers
    for (int i = 0; i < 9; i++) begin
      send("R4", 1'b1, 16'h03CE, 2'd0, 64'(i));
      send("R4", 1'b1, 16'h03CF, 2'd0, 64'hFF);
      send("R4 gfx data", 1'b0, 16'h03CF, 2'd0, 64'h0);
    end
    check_regs("R4");
    send("R4", 1'b1, 16'h03CE, 2'd0, 64'h20);
    send("R4", 1'b1, 16'h03CF, 2'd0, 64'hA5);
    send("R4 gfx 0x20", 1'b0, 16'h03CF, 2'd0, 64'h0);
    send("R4", 1'b1, 16'h03CE, 2'd0, 64'hFF);
    send("R4", 1'b1, 16'h03CF, 2'd0, 64'h3C);
    send("R4 gfx 0xFF", 1'b0, 16'h03CF, 2'd0, 64'h0);
    send("R8", 1'b1, 16'h03CE, 2'd0, 64'h09);
    send("R8", 1'b1, 16'h03CF, 2'd0, 64'h77);
    send("R8 gfx 9 remote", 1'b0, 16'h03CF, 2'd0, 64'h0);
    check_regs("R4 upper");

    // R5 sequencer out of range
    send("R5", 1'b1, 16'h03C4, 2'd0, 64'h09);
    send("R5", 1'b1, 16'h03C5, 2'd0, 64'h55);
    check_regs("R5");
    send("R5 oob read", 1'b0, 16'h03C5, 2'd0, 64'h0);

    // R9 multi-byte, little-endian
    send("R9", 1'b1, 16'h03C4, 2'd1, 64'h2A03);
    check_regs("R9 word write");
    send("R9 dword read", 1'b0, 16'h03C4, 2'd2, 64'h0);
    send("R9 qword read", 1'b0, 16'h03CA, 2'd3, 64'h0);
    // R12 bytes outside the ports are dropped
    send("R12", 1'b1, 16'h03C0, 2'd3, 64'h9977_1F01_DEAD_BEEF);
    check_regs("R12");
    send("R12 unused ports", 1'b0, 16'h03C6, 2'd1, 64'h0);

    // R6 / R7 standard mode entry
    send("R6", 1'b1, 16'h03C4, 2'd0, 64'h07);
    send("R6", 1'b1, 16'h03C5, 2'd0, 64'h00);
    send("R6", 1'b1, 16'h03CE, 2'd0, 64'h06);
    check("R6 still off", 72'(std_mode), 72'(0));
    send("R6", 1'b1, 16'h03CF, 2'd0, 64'hF5);
    check("R6 one edge after write", 72'(std_mode), 72'(0));
    @(negedge clk);
    check("R6 mode on", 72'(std_mode), 72'(1));
    check("R7 restart pulse", 72'(cache_restart), 72'(1));
    check("R7 cache on", 72'(cache_en), 72'(1));
    @(negedge clk);
    check("R7 pulse ends", 72'(cache_restart), 72'(0));
    send("R6", 1'b1, 16'h03CF, 2'd0, 64'h07);
    @(negedge clk);
    check("R6 mode off", 72'(std_mode), 72'(0));
    check("R7 cache sticky", 72'(cache_en), 72'(1));
    check("R7 no pulse on exit", 72'(cache_restart), 72'(0));
    send("R7", 1'b1, 16'h03CF, 2'd0, 64'h05);
    @(negedge clk);
    check("R7 re-entry pulse", 72'(cache_restart), 72'(1));

    repeat (12) @(negedge clk);
    check("R10 all responses seen", 72'(q_d.size()), 72'(0));
    finish_run();
  end

endmodule